// File: doc/BRIEF.md
# First-Word Fall-Through Stream FIFO

A single-clock FIFO that puts the oldest stored word on its output as soon as that word exists. The consumer never has to ask for data first. The output side says only whether the word it shows is valid. A handshake on that side means "this word has been taken, show the next one". The core inside works with native controls: write enable, full, a read enable that acknowledges the shown word, and an empty flag that means "output not valid". A thin wrapper turns these into a valid/ready stream on both sides.

One clock drives every register, and the reset is synchronous to it. There is no clock-domain synchronization. Capacity is `DEPTH` words in the storage array plus one in the output register. A word written into an empty FIFO goes straight into the output register and appears on the next clock edge. No combinational path runs from the input data to the output data.

Top module: `fwft_stream_fifo`

## Requirements
- R1: In the cycle after reset is applied, `out_valid` is 0 and `in_ready` is 1.
- R2: A word accepted (`in_valid && in_ready`) while the FIFO is empty appears on `out_data` with `out_valid` high after the next clock edge, whatever `out_ready` does. `out_valid` never rises without an accepted write in the cycle before.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R4: Words leave in exactly the order they were accepted, and none is lost or duplicated.
- R5: `in_ready` is 0 exactly when `DEPTH+1` words are held. An `in_valid` offered while `in_ready` is 0 stores nothing.
- R6: When the only held word is consumed (`out_valid && out_ready`) and no write is accepted in that cycle, `out_valid` is 0 in the next cycle.
- R7: With `out_ready` held at 1 and two or more words held, `out_valid` stays high across the transfer, so one word leaves per cycle.
- R8: With exactly one word held, a consume and an accepted write in the same cycle keep `out_valid` high, and the new word shows in the following cycle.
- R9: A transfer happens only on a cycle where valid and ready are both 1 on that side. `out_ready` is ignored while `out_valid` is 0, and `in_ready` equals "not full".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single shared clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can accept a word (not full) |
| in_data | input | DATA_W | Word to store |
| out_valid | output | 1 | `out_data` holds a valid word (not empty) |
| out_ready | input | 1 | Consumer takes the shown word |
| out_data | output | DATA_W | Oldest stored word |

## Verification
The assertions assume a few things about the inputs. Reset is driven synchronously and held for at least one edge. All inputs are free of X and settle before each rising edge. `in_data` needs no hold, because the design samples it only on an accepted edge. The checker keeps its own occupancy count from the handshakes at the ports, so the full, last-word and simultaneous-transfer properties rely on those handshakes being the only way words enter or leave. The stimulus changes inputs only at the falling edge. It also drives `out_ready` high while nothing is valid, and `in_valid` high against a full FIFO, so the gating in R9 and R5 is exercised without breaking the native rule against reading an empty core.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
    // Where the output register is refilled from on a given cycle
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_MEM    = 2'd1,
        SRC_BYPASS = 2'd2
    } fill_src_e;
endpackage

// File: rtl/fwft_mem.sv
module fwft_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/fwft_core.sv
module fwft_core
    import fwft_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic              oval;
        logic [DATA_W-1:0] odata;
    } state_t;

    state_t    st_q, st_d;
    fill_src_e src_d;
    logic      mem_we_d;
    logic      wr_ok, pop, slot_free;
    logic [DATA_W-1:0] mem_rdata;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = !st_q.oval;
    assign dout  = st_q.odata;

    assign wr_ok     = wr_en && !full;
    assign pop       = rd_en && st_q.oval;
    assign slot_free = !st_q.oval || pop;

    always_comb begin
        st_d  = st_q;
        src_d = SRC_NONE;
        if (slot_free) begin
            if (st_q.cnt != '0) begin
                src_d = SRC_MEM;
            end else if (wr_ok) begin
                src_d = SRC_BYPASS;
            end
        end

        case (src_d)
            SRC_MEM: begin
                st_d.odata = mem_rdata;
                st_d.oval  = 1'b1;
                st_d.rptr  = bump(st_q.rptr);
            end
            SRC_BYPASS: begin
                st_d.odata = din;
                st_d.oval  = 1'b1;
            end
            default: begin
                if (slot_free) begin
                    st_d.oval = 1'b0;
                end
            end
        endcase

        mem_we_d = wr_ok && (src_d != SRC_BYPASS);
        if (mem_we_d) begin
            st_d.wptr = bump(st_q.wptr);
        end
        st_d.cnt = st_q.cnt + CW'(mem_we_d) - CW'(src_d == SRC_MEM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fwft_mem #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we_d),
        .waddr(st_q.wptr),
        .wdata(din),
        .raddr(st_q.rptr),
        .rdata(mem_rdata)
    );
endmodule

// File: rtl/fwft_stream_fifo.sv
module fwft_stream_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic core_full, core_empty, core_wr, core_rd;
    logic [DATA_W-1:0] core_dout;

    assign in_ready  = !core_full;
    assign core_wr   = in_valid && in_ready;
    assign out_valid = !core_empty;
    assign core_rd   = out_valid && out_ready;
    assign out_data  = core_dout;

    fwft_core #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_core (
        .clk  (clk),
        .rst  (rst),
        .wr_en(core_wr),
        .din  (in_data),
        .full (core_full),
        .rd_en(core_rd),
        .dout (core_dout),
        .empty(core_empty)
    );
endmodule

// File: rtl/fwft_chk.sv
module fwft_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int OW = $clog2(DEPTH + 2);

    logic [OW-1:0] occ_q;
    logic push, take;

    assign push = in_valid && in_ready;
    assign take = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OW'(push) - OW'(take);
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready)); // R1

    AST_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(push)); // R2

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3

    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (occ_q == OW'(DEPTH + 1)) == !in_ready); // R5

    AST_LAST_WORD_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (occ_q == OW'(1) && take && !push) |=> !out_valid); // R6

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (occ_q >= OW'(2) && take) |=> out_valid); // R7

    AST_ONE_WORD_SWAP: assert property (@(posedge clk) disable iff (rst)
        (occ_q == OW'(1) && take && push) |=> out_valid); // R8

    AST_VALID_MATCHES_FILL: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ_q != '0)); // R9
endmodule

bind fwft_stream_fifo fwft_chk #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/sim_fwft_stream_fifo.sv
`timescale 1ns/1ps
module sim_fwft_stream_fifo;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int CAP    = DEPTH + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] next_word = 8'h10;

    always #2.5 clk = ~clk;

    fwft_stream_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare ports against the queue model (called at the falling edge)
    task automatic compare();
        bit ev;
        ev = (model_q.size() != 0);
        check(tag, "out_valid", int'(out_valid), int'(ev));
        check(tag, "in_ready", int'(in_ready), int'(model_q.size() < CAP));
        if (ev) check(tag, "out_data", int'(out_data), int'(model_q[0]));
    endtask

    // Drive one cycle: compare, apply inputs, clock, update model
    task automatic step(input bit iv, input bit ordy);
        bit acc_in, acc_out;
        @(negedge clk);
        compare();
        in_valid  = iv;
        in_data   = next_word;
        out_ready = ordy;
        acc_in  = iv && (model_q.size() < CAP);
        acc_out = ordy && (model_q.size() != 0);
        @(posedge clk);
        if (acc_out) void'(model_q.pop_front());
        if (acc_in) begin
            model_q.push_back(next_word);
            next_word = next_word + 8'd7;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ready after reset", int'(in_ready), 1);

        // R2 / R3: write into empty, consumer idle, word shows and holds
        tag = "R2";
        step(1'b1, 1'b0);
        tag = "R3";
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R6: consume the only word, no write
        tag = "R6";
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);

        // R5: fill past capacity with ready low; extra offers ignored
        tag = "R5";
        for (int i = 0; i < CAP + 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        // R7 / R4: drain back to back
        tag = "R7";
        for (int i = 0; i < CAP + 1; i++) step(1'b0, 1'b1);
        // R9: ready high with nothing valid has no effect
        tag = "R9";
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);

        // R8: one word held, simultaneous consume and write
        tag = "R8";
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);

        // R4 / R9: mixed traffic with a fixed seed
        tag = "R4";
        void'($urandom(32'd77));
        for (int i = 0; i < 600; i++) begin
            step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0));
        end
        tag = "R9";
        for (int i = 0; i < 200; i++) begin
            step(($urandom_range(0, 4) == 0), ($urandom_range(0, 4) != 0));
        end
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule